// File: doc/BRIEF.md
# Completion Ring Manager with One-Shot Arming

This block tracks a set of completion rings that hardware fills and host software drains. Each ring lives in host memory as an array of 32-byte slots. The hardware side of the chip sends an enqueue request that names a ring. The block answers with the host address of the next free slot and advances that ring's head pointer. If the ring is inactive or full, the block refuses the request and leaves the pointer where it was. Software owns the tail pointer. It writes the tail back through the register port after it has consumed entries.

Software asks to be told about new completions by arming a ring. When an armed ring takes a completion, the block raises one event request and disarms the ring. The event carries a type code, the source ring number and the ring's interrupt index. Software re-arms the ring once it has drained it. A continuous flag keeps the ring armed, so that every completion raises an event. Events leave through a valid/ready stream. When several rings have events pending, a round-robin arbiter chooses between them.

Each ring has a 32-byte register window, reached through a plain 32-bit write/read port. The window number is the upper part of the register address.

Top module: `cpl_queue_mgr`

## Requirements
- R1: Each ring has a 32-byte register window. The window offsets are:
  - 0x00: base address, low word.
  - 0x04: base address, high word.
  - 0x08: control. Bit 31 is active. Bits 3:0 are log2 of the ring size.
  - 0x0C: interrupt index. Bits 15:0 are the index, bit 30 is continuous and bit 31 is arm.
  - 0x10: head pointer, in bits 15:0.
  - 0x18: tail pointer, in bits 15:0.
  A read returns the current value on `reg_rd_data`, with `reg_rd_valid` high, one cycle after `reg_rd_en`.
- R2: An accepted enqueue on an active ring that is not full answers with `resp_ok`=1 and `resp_addr` = base + (head mod size) × 32. It then increments the 16-bit head pointer, which wraps from 0xFFFF to 0x0000.
- R3: A ring is full when (head − tail) mod 65536 ≥ 2^log2size. An enqueue to a full ring answers `resp_ok`=0 and `resp_addr`=0, and leaves the head unchanged.
- R4: An inactive ring refuses every enqueue (`resp_ok`=0) and never produces an event.
- R5: A completion on an armed ring that is not continuous produces exactly one event and clears the arm bit. The event carries `evt_type` = the EVENT_TYPE parameter (0 = transmit, 1 = receive), `evt_source` = the ring number and `evt_irq` = bits 15:0 of the interrupt-index register.
- R6: A completion on a ring that is not armed produces no event.
- R7: Writing the arm bit while head ≠ tail produces an event at once. Writing the arm bit while head = tail produces none.
- R8: With the continuous bit set, every completion on an armed ring produces an event, and the arm bit stays set. A completion that arrives while that ring's event is still waiting in the arbiter merges into the waiting event.
- R9: `req_ready` = !`resp_valid` | `resp_ready`. While `resp_ready` is low, `resp_valid` and the response fields hold steady. While `evt_ready` is low, `evt_valid` and the event fields hold steady.
- R10: Rings with waiting events are served in round-robin order. The search starts at the ring after the one served last.
- R11: After reset every register reads 0, and `resp_valid`, `evt_valid` and `reg_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | QW+5 | Write address: ring number above a 5-bit byte offset |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | QW+5 | Read address |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rd_data | output | 32 | Read data |
| req_valid | input | 1 | Enqueue request valid |
| req_ready | output | 1 | Enqueue request accepted when high with valid |
| req_queue | input | QW | Target ring number |
| resp_valid | output | 1 | Enqueue response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_ok | output | 1 | 1 = slot granted, 0 = refused |
| resp_queue | output | QW | Ring number of this response |
| resp_addr | output | ADDR_W | Host address of the granted slot |
| evt_valid | output | 1 | Event request valid |
| evt_ready | input | 1 | Event consumer ready |
| evt_type | output | 16 | Source type code |
| evt_source | output | 16 | Source ring number |
| evt_irq | output | 16 | Interrupt index of the source ring |

## Verification
The bench builds the block with four rings, 64-bit addresses, a size limit of 2^15 and the receive type code (1). Four rings are enough for the arbiter's rotation to show: the order it serves differs from what a fixed priority would pick. Software sets the ring size at run time, so most tests use a four-slot ring. This makes the full boundary, the slot-index wrap and the full test across the 16-bit pointer wrap all reachable in a handful of enqueues.

// File: rtl/cqm_pkg.sv
package cqm_pkg;
  localparam int REG_W      = 32;
  localparam int OFF_W      = 5;
  localparam int PTR_W      = 16;
  localparam int IRQ_W      = 16;
  localparam int LOG_W      = 4;
  localparam int SLOT_SHIFT = 5;

  // byte offsets inside one ring window
  localparam logic [OFF_W-1:0] OFS_BASE_LO = 5'h00;
  localparam logic [OFF_W-1:0] OFS_BASE_HI = 5'h04;
  localparam logic [OFF_W-1:0] OFS_CTRL    = 5'h08;
  localparam logic [OFF_W-1:0] OFS_IRQ     = 5'h0C;
  localparam logic [OFF_W-1:0] OFS_HEAD    = 5'h10;
  localparam logic [OFF_W-1:0] OFS_TAIL    = 5'h18;

  localparam int BIT_ACTIVE = 31;
  localparam int BIT_ARM    = 31;
  localparam int BIT_CONT   = 30;

  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/cqm_queue_regs.sv
module cqm_queue_regs
  import cqm_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int MAX_LOG = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [REG_W-1:0]  rd_word,
  input  logic              enq_commit,
  input  logic              grant,
  output logic              full,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              active,
  output logic              pending,
  output logic [IRQ_W-1:0]  irq_idx
);
  localparam logic [LOG_W-1:0] LOG_CAP = LOG_W'(MAX_LOG);

  logic [63:0]      base_q;
  logic [LOG_W-1:0] log_q;
  logic             active_q, arm_q, cont_q, pend_q;
  logic [IRQ_W-1:0] irq_q;
  ptr_t             head_q, tail_q;

  logic [LOG_W-1:0] eff_log;
  logic [PTR_W:0]   ring_size;
  ptr_t             used, mask;
  logic             wr_ctrl, wr_irq, wr_head, wr_tail;
  logic             fire, arm_nx, cont_nx, active_nx;

  // occupancy and slot address (R2, R3)
  always_comb begin
    eff_log   = (log_q > LOG_CAP) ? LOG_CAP : log_q;
    ring_size = (PTR_W+1)'(1) << eff_log;
    used      = head_q - tail_q;
    mask      = ring_size[PTR_W-1:0] - ptr_t'(1);
    full      = ({1'b0, used} >= ring_size);
    slot_addr = base_q[ADDR_W-1:0] + (ADDR_W'(head_q & mask) << SLOT_SHIFT);
  end

  assign wr_ctrl = wr_en && (wr_off == OFS_CTRL);
  assign wr_irq  = wr_en && (wr_off == OFS_IRQ);
  assign wr_head = wr_en && (wr_off == OFS_HEAD);
  assign wr_tail = wr_en && (wr_off == OFS_TAIL);

  // arming: completion on an armed ring (R5, R8) or arm written with work
  // already present (R7); only an active ring fires (R4)
  always_comb begin
    cont_nx   = wr_irq  ? wr_data[BIT_CONT]   : cont_q;
    active_nx = wr_ctrl ? wr_data[BIT_ACTIVE] : active_q;
    fire      = active_q &&
                ((arm_q && enq_commit) ||
                 (wr_irq && wr_data[BIT_ARM] && (head_q != tail_q)));
    arm_nx    = wr_irq ? wr_data[BIT_ARM] : arm_q;
    if (fire && !cont_nx) arm_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      log_q    <= '0;
      active_q <= 1'b0;
      arm_q    <= 1'b0;
      cont_q   <= 1'b0;
      pend_q   <= 1'b0;
      irq_q    <= '0;
      head_q   <= '0;
      tail_q   <= '0;
    end else begin
      if (wr_en && wr_off == OFS_BASE_LO) base_q[31:0]  <= wr_data;
      if (wr_en && wr_off == OFS_BASE_HI) base_q[63:32] <= wr_data;
      if (wr_ctrl) log_q <= wr_data[LOG_W-1:0];
      if (wr_irq)  irq_q <= wr_data[IRQ_W-1:0];
      if (wr_tail) tail_q <= wr_data[PTR_W-1:0];
      if (wr_head)         head_q <= wr_data[PTR_W-1:0];
      else if (enq_commit) head_q <= head_q + ptr_t'(1);
      active_q <= active_nx;
      arm_q    <= arm_nx;
      cont_q   <= cont_nx;
      if (!active_nx)  pend_q <= 1'b0;
      else if (fire)   pend_q <= 1'b1;
      else if (grant)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_off)
      OFS_BASE_LO: rd_word = base_q[31:0];
      OFS_BASE_HI: rd_word = base_q[63:32];
      OFS_CTRL:    rd_word = {active_q, {(REG_W-1-LOG_W){1'b0}}, log_q};
      OFS_IRQ:     rd_word = {arm_q, cont_q, {(REG_W-2-IRQ_W){1'b0}}, irq_q};
      OFS_HEAD:    rd_word = {{(REG_W-PTR_W){1'b0}}, head_q};
      OFS_TAIL:    rd_word = {{(REG_W-PTR_W){1'b0}}, tail_q};
      default:     rd_word = '0;
    endcase
  end

  assign active  = active_q;
  assign pending = pend_q;
  assign irq_idx = irq_q;
endmodule

// File: rtl/cqm_enq_port.sv
module cqm_enq_port #(
  parameter int NQ     = 4,
  parameter int QW     = 2,
  parameter int ADDR_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [QW-1:0]              req_queue,
  output logic                       resp_valid,
  input  logic                       resp_ready,
  output logic                       resp_ok,
  output logic [QW-1:0]              resp_queue,
  output logic [ADDR_W-1:0]          resp_addr,
  input  logic [NQ-1:0]              q_full,
  input  logic [NQ-1:0]              q_active,
  input  logic [NQ-1:0][ADDR_W-1:0]  q_slot,
  output logic [NQ-1:0]              commit
);
  logic              take, sel_ok;
  logic              sel_full, sel_act;
  logic [ADDR_W-1:0] sel_addr;

  // single response register: a new request may enter while the old
  // response leaves (R9)
  assign req_ready = !resp_valid || resp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    sel_full = 1'b0;
    sel_act  = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < NQ; i++) begin
      if (req_queue == QW'(i)) begin
        sel_full = q_full[i];
        sel_act  = q_active[i];
        sel_addr = q_slot[i];
      end
    end
    // refuse full (R3) or inactive (R4) rings
    sel_ok = sel_act && !sel_full;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_commit
    assign commit[g] = take && sel_ok && (req_queue == QW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_queue <= '0;
      resp_addr  <= '0;
    end else if (take) begin
      resp_valid <= 1'b1;
      resp_ok    <= sel_ok;
      resp_queue <= req_queue;
      resp_addr  <= sel_ok ? sel_addr : '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cqm_event_arb.sv
module cqm_event_arb
  import cqm_pkg::*;
#(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NQ-1:0]             eligible,
  input  logic [NQ-1:0][IRQ_W-1:0]  irq_idx,
  output logic [NQ-1:0]             grant,
  output logic                      evt_valid,
  input  logic                      evt_ready,
  output logic [QW-1:0]             evt_src,
  output logic [IRQ_W-1:0]          evt_irq
);
  logic [QW-1:0] last_q;
  logic          load, found;
  logic [QW-1:0] pick;

  assign load = !evt_valid || evt_ready;

  // round-robin search starting after the last served ring (R10)
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= NQ; off++) begin
      int idx;
      idx = int'(last_q) + off;
      if (idx >= NQ) idx = idx - NQ;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = QW'(idx);
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_grant
    assign grant[g] = load && found && (pick == QW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_src   <= '0;
      evt_irq   <= '0;
      last_q    <= QW'(NQ-1);
    end else if (load && found) begin
      evt_valid <= 1'b1;
      evt_src   <= pick;
      evt_irq   <= irq_idx[pick];
      last_q    <= pick;
    end else if (evt_ready) begin
      evt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cpl_queue_mgr.sv
module cpl_queue_mgr
  import cqm_pkg::*;
#(
  parameter int          NUM_QUEUES = 4,
  parameter int          ADDR_W     = 64,
  parameter int          MAX_LOG    = 15,
  parameter logic [15:0] EVENT_TYPE = 16'd0,
  localparam int         QW         = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int         RA_W       = QW + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [RA_W-1:0]   reg_rd_addr,
  output logic              reg_rd_valid,
  output logic [31:0]       reg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [QW-1:0]     req_queue,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_ok,
  output logic [QW-1:0]     resp_queue,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [15:0]       evt_type,
  output logic [15:0]       evt_source,
  output logic [15:0]       evt_irq
);
  logic [NUM_QUEUES-1:0]              full_vec, active_vec, pend_vec;
  logic [NUM_QUEUES-1:0]              commit_vec, grant_vec;
  logic [NUM_QUEUES-1:0][ADDR_W-1:0]  slot_vec;
  logic [NUM_QUEUES-1:0][IRQ_W-1:0]   irq_vec;
  logic [NUM_QUEUES-1:0][REG_W-1:0]   rd_vec;
  logic [QW-1:0]                      wr_q, rd_q, arb_src;
  logic [REG_W-1:0]                   rd_sel;

  assign wr_q = reg_wr_addr[RA_W-1:OFF_W];
  assign rd_q = reg_rd_addr[RA_W-1:OFF_W];

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_ring
    cqm_queue_regs #(
      .ADDR_W  (ADDR_W),
      .MAX_LOG (MAX_LOG)
    ) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en && (wr_q == QW'(g))),
      .wr_off     (reg_wr_addr[OFF_W-1:0]),
      .wr_data    (reg_wr_data),
      .rd_off     (reg_rd_addr[OFF_W-1:0]),
      .rd_word    (rd_vec[g]),
      .enq_commit (commit_vec[g]),
      .grant      (grant_vec[g]),
      .full       (full_vec[g]),
      .slot_addr  (slot_vec[g]),
      .active     (active_vec[g]),
      .pending    (pend_vec[g]),
      .irq_idx    (irq_vec[g])
    );
  end

  cqm_enq_port #(
    .NQ     (NUM_QUEUES),
    .QW     (QW),
    .ADDR_W (ADDR_W)
  ) u_enq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_queue  (req_queue),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_ok    (resp_ok),
    .resp_queue (resp_queue),
    .resp_addr  (resp_addr),
    .q_full     (full_vec),
    .q_active   (active_vec),
    .q_slot     (slot_vec),
    .commit     (commit_vec)
  );

  cqm_event_arb #(
    .NQ (NUM_QUEUES),
    .QW (QW)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .eligible  (pend_vec & active_vec),
    .irq_idx   (irq_vec),
    .grant     (grant_vec),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_src   (arb_src),
    .evt_irq   (evt_irq)
  );

  assign evt_type   = EVENT_TYPE;
  assign evt_source = 16'(arb_src);

  // register read-back, one cycle latency (R1)
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_QUEUES; i++)
      if (rd_q == QW'(i)) rd_sel = rd_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_valid <= 1'b0;
      reg_rd_data  <= '0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) reg_rd_data <= rd_sel;
    end
  end
endmodule

// File: rtl/cpl_queue_mgr_chk.sv
module cpl_queue_mgr_chk #(
  parameter int NQ     = 4,
  parameter int QW     = 2,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [QW-1:0]     req_queue,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_ok,
  input logic [ADDR_W-1:0] resp_addr,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [15:0]       evt_source,
  input logic [15:0]       evt_irq,
  input logic [NQ-1:0]     grant_vec,
  input logic [NQ-1:0]     active_vec
);
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_addr) && $stable(resp_ok)); // R9
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_source) && $stable(evt_irq)); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> req_ready); // R9
  AST_INACTIVE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (int'(req_queue) < NQ) && !active_vec[req_queue]
    |=> resp_valid && !resp_ok); // R4
  AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~active_vec) == '0); // R4
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R10
endmodule

bind cpl_queue_mgr cpl_queue_mgr_chk #(
  .NQ     (NUM_QUEUES),
  .QW     (QW),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_queue  (req_queue),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_ok    (resp_ok),
  .resp_addr  (resp_addr),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .evt_source (evt_source),
  .evt_irq    (evt_irq),
  .grant_vec  (grant_vec),
  .active_vec (active_vec)
);

// File: tb/cpl_queue_mgr_bench.sv
module cpl_queue_mgr_bench;
  localparam int NQ = 4;
  localparam int QW = 2;
  localparam int RA = QW + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [RA-1:0] reg_wr_addr = '0;
  logic [31:0]   reg_wr_data = '0;
  logic          reg_rd_en = 1'b0;
  logic [RA-1:0] reg_rd_addr = '0;
  logic          reg_rd_valid;
  logic [31:0]   reg_rd_data;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [QW-1:0] req_queue = '0;
  logic          resp_valid;
  logic          resp_ready = 1'b1;
  logic          resp_ok;
  logic [QW-1:0] resp_queue;
  logic [63:0]   resp_addr;
  logic          evt_valid;
  logic          evt_ready = 1'b0;
  logic [15:0]   evt_type, evt_source, evt_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cpl_queue_mgr #(
    .NUM_QUEUES (NQ),
    .ADDR_W     (64),
    .MAX_LOG    (15),
    .EVENT_TYPE (16'd1)
  ) u_cpl_queue_mgr (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_ok(resp_ok),
    .resp_queue(resp_queue), .resp_addr(resp_addr),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_type(evt_type),
    .evt_source(evt_source), .evt_irq(evt_irq)
  );

  function automatic logic [63:0] base_of(int q);
    return 64'h0000_0040_0000_0000 + 64'(q) * 64'h1000;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int q, logic [4:0] off, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = {QW'(q), off}; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int q, logic [4:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = {QW'(q), off};
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
    check(reg_rd_valid == 1'b1, "R1", "read valid", 64'(reg_rd_valid), 64'd1);
  endtask

  task automatic cfg(int q, logic [3:0] lg, logic [31:0] irq, logic [15:0] hd, logic [15:0] tl, bit act);
    wr(q, 5'h08, 32'h0);
    wr(q, 5'h00, base_of(q)[31:0]);
    wr(q, 5'h04, base_of(q)[63:32]);
    wr(q, 5'h10, {16'h0, hd});
    wr(q, 5'h18, {16'h0, tl});
    wr(q, 5'h0C, irq);
    wr(q, 5'h08, {act, 27'h0, lg});
  endtask

  task automatic enq(int q, output logic ok, output logic [63:0] addr);
    @(negedge clk);
    resp_ready = 1'b1; req_valid = 1'b1; req_queue = QW'(q);
    @(negedge clk);
    req_valid = 1'b0;
    ok = resp_ok; addr = resp_addr;
  endtask

  task automatic enq_expect(int q, bit exp_ok, logic [63:0] exp_addr, string req);
    logic ok; logic [63:0] a;
    enq(q, ok, a);
    check(ok == exp_ok, req, "resp_ok", 64'(ok), 64'(exp_ok));
    check(a == exp_addr, req, "resp_addr", a, exp_addr);
  endtask

  task automatic expect_event(int src, logic [15:0] irq, string req);
    repeat (2) @(negedge clk);
    check(evt_valid == 1'b1, req, "evt_valid", 64'(evt_valid), 64'd1);
    check(evt_source == 16'(src), req, "evt_source", 64'(evt_source), 64'(src));
    check(evt_irq == irq, req, "evt_irq", 64'(evt_irq), 64'(irq));
    check(evt_type == 16'd1, req, "evt_type", 64'(evt_type), 64'd1);
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
  endtask

  task automatic expect_none(string req);
    repeat (3) @(negedge clk);
    check(evt_valid == 1'b0, req, "no event", 64'(evt_valid), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] d;
    check(resp_valid == 1'b0, "R11", "resp_valid after reset", 64'(resp_valid), 64'd0);
    check(evt_valid == 1'b0, "R11", "evt_valid after reset", 64'(evt_valid), 64'd0);
    check(reg_rd_valid == 1'b0, "R11", "rd_valid after reset", 64'(reg_rd_valid), 64'd0);
    rd(0, 5'h08, d); check(d == 32'h0, "R11", "ctrl after reset", 64'(d), 64'd0);
    rd(3, 5'h10, d); check(d == 32'h0, "R11", "head after reset", 64'(d), 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(1, 5'h00, 32'hDEAD_BEE0);
    wr(1, 5'h04, 32'h0000_1234);
    wr(1, 5'h08, 32'h8000_0003);
    wr(1, 5'h0C, 32'h4000_00A5);
    wr(1, 5'h18, 32'h0000_0007);
    rd(1, 5'h00, d); check(d == 32'hDEAD_BEE0, "R1", "base lo", 64'(d), 64'hDEAD_BEE0);
    rd(1, 5'h04, d); check(d == 32'h0000_1234, "R1", "base hi", 64'(d), 64'h1234);
    rd(1, 5'h08, d); check(d == 32'h8000_0003, "R1", "ctrl", 64'(d), 64'h8000_0003);
    rd(1, 5'h0C, d); check(d == 32'h4000_00A5, "R1", "irq reg", 64'(d), 64'h4000_00A5);
    rd(1, 5'h18, d); check(d == 32'h7, "R1", "tail", 64'(d), 64'h7);
    rd(2, 5'h00, d); check(d == 32'h0, "R1", "other window untouched", 64'(d), 64'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    logic [63:0] b;
    b = base_of(0);
    cfg(0, 4'd2, 32'h0, 16'h0, 16'h0, 1'b1);
    enq_expect(0, 1'b1, b, "R2");
    enq_expect(0, 1'b1, b + 64'd32, "R2");
    rd(0, 5'h10, d); check(d == 32'd2, "R2", "head advanced", 64'(d), 64'd2);
    cfg(0, 4'd2, 32'h0, 16'h3, 16'h3, 1'b1);
    enq_expect(0, 1'b1, b + 64'd96, "R2");
    enq_expect(0, 1'b1, b, "R2");
    cfg(0, 4'd2, 32'h0, 16'hFFFF, 16'hFFFF, 1'b1);
    enq_expect(0, 1'b1, b + 64'd96, "R2");
    rd(0, 5'h10, d); check(d == 32'h0, "R2", "head 16-bit wrap", 64'(d), 64'h0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    logic [63:0] b;
    b = base_of(0);
    cfg(0, 4'd2, 32'h0, 16'h0, 16'h0, 1'b1);
    for (int k = 0; k < 4; k++) enq_expect(0, 1'b1, b + 64'(k) * 64'd32, "R3");
    enq_expect(0, 1'b0, 64'd0, "R3");
    rd(0, 5'h10, d); check(d == 32'd4, "R3", "head held when full", 64'(d), 64'd4);
    wr(0, 5'h18, 32'd1);
    enq_expect(0, 1'b1, b, "R3");
    cfg(0, 4'd2, 32'h0, 16'h0001, 16'hFFFE, 1'b1);
    enq_expect(0, 1'b1, b + 64'd32, "R3");
    enq_expect(0, 1'b0, 64'd0, "R3");
  endtask

  task automatic t_inactive();
    logic [31:0] d;
    cfg(1, 4'd2, 32'h8000_0011, 16'h0, 16'h0, 1'b0);
    enq_expect(1, 1'b0, 64'd0, "R4");
    expect_none("R4");
    rd(1, 5'h10, d); check(d == 32'h0, "R4", "inactive head", 64'(d), 64'h0);
  endtask

  task automatic t_unarmed();
    cfg(0, 4'd2, 32'h0000_0055, 16'h0, 16'h0, 1'b1);
    enq_expect(0, 1'b1, base_of(0), "R6");
    expect_none("R6");
  endtask

  task automatic t_armed();
    logic [31:0] d;
    wr(0, 5'h18, 32'd1);               // drained: head == tail == 1
    wr(0, 5'h0C, 32'h8000_0055);
    expect_none("R7");                 // armed on empty ring: silent
    enq_expect(0, 1'b1, base_of(0) + 64'd32, "R5");
    expect_event(0, 16'h0055, "R5");
    rd(0, 5'h0C, d); check(d == 32'h0000_0055, "R5", "arm cleared", 64'(d), 64'h55);
    enq_expect(0, 1'b1, base_of(0) + 64'd64, "R5");
    expect_none("R5");
  endtask

  task automatic t_arm_now();
    logic [31:0] d;
    wr(0, 5'h0C, 32'h8000_0055);       // head 3, tail 1
    expect_event(0, 16'h0055, "R7");
    rd(0, 5'h0C, d); check(d == 32'h0000_0055, "R7", "arm cleared", 64'(d), 64'h55);
  endtask

  task automatic t_cont();
    logic [31:0] d;
    cfg(2, 4'd2, 32'hC000_0007, 16'h0, 16'h0, 1'b1);
    expect_none("R8");
    enq_expect(2, 1'b1, base_of(2), "R8");
    expect_event(2, 16'h0007, "R8");
    enq_expect(2, 1'b1, base_of(2) + 64'd32, "R8");
    expect_event(2, 16'h0007, "R8");
    rd(2, 5'h0C, d); check(d == 32'hC000_0007, "R8", "arm kept", 64'(d), 64'hC000_0007);
  endtask

  task automatic t_round_robin();
    cfg(1, 4'd2, 32'h0000_0011, 16'h1, 16'h0, 1'b1);
    cfg(2, 4'd2, 32'h0000_0022, 16'h1, 16'h0, 1'b1);
    cfg(3, 4'd2, 32'h0000_0033, 16'h1, 16'h0, 1'b1);
    wr(2, 5'h0C, 32'h8000_0022);
    repeat (2) @(negedge clk);
    check(evt_valid && evt_source == 16'd2, "R10", "first served", 64'(evt_source), 64'd2);
    wr(1, 5'h0C, 32'h8000_0011);
    wr(3, 5'h0C, 32'h8000_0033);
    check(evt_valid && evt_source == 16'd2 && evt_irq == 16'h22, "R9", "event held",
          64'(evt_source), 64'd2);
    expect_event(2, 16'h0022, "R10");
    expect_event(3, 16'h0033, "R10");
    expect_event(1, 16'h0011, "R10");
    expect_none("R10");
  endtask

  task automatic t_backpressure();
    logic [63:0] a;
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_queue = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, "R9", "resp_valid", 64'(resp_valid), 64'd1);
    check(req_ready == 1'b0, "R9", "req_ready low", 64'(req_ready), 64'd0);
    a = resp_addr;
    check(a == base_of(3) + 64'd32, "R9", "resp_addr", a, base_of(3) + 64'd32);
    repeat (3) @(negedge clk);
    check(resp_valid && resp_addr == a && resp_ok, "R9", "resp held", resp_addr, a);
    resp_ready = 1'b1;
    @(negedge clk);
    check(resp_valid == 1'b0, "R9", "resp drained", 64'(resp_valid), 64'd0);
    check(req_ready == 1'b1, "R9", "req_ready high", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_addr();
    t_full();
    t_inactive();
    t_unarmed();
    t_armed();
    t_arm_now();
    t_cont();
    t_round_robin();
    t_backpressure();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule